// File: doc/BRIEF.md
# Raster Timing Generator with Colour-Bar Test Mode

This block produces the raster timing of a display controller: horizontal sync, vertical sync, composite sync, a data-enable strobe and the pixel column and row being scanned. It is configured through a small set of 32-bit words written on a simple synchronous register port. The active width and height come from a size word. The front porch, sync pulse and back porch of each axis come from one packed timing word per axis.

A mode field gates the whole generator. When it is off, the outputs sit idle and the counters wait at zero. In pass mode, the pixel word presented on the input is forwarded during the active area. In bar mode, the active width is cut into eight equal columns, and each column is painted from its own programmable colour word. Software turns the generator off, rewrites the timing and then turns it on again. Timing writes made while it runs are held back until the next frame begins. A vertical-blank event feeds a write-one-to-clear status word, and a mask word filters that status onto a single interrupt line.

Top module: `raster_timing_ctrl`

## Requirements
- R1: The mode word (address 0, bits 2:0) runs the generator only for value 1 (pass) or 4 (bars). For any other value, within one clock edge, de is low, the syncs sit at their inactive level and pix_x and pix_y read zero. The next run starts from column 0, row 0.
- R2: Address 3 holds the active width in bits 10:0 and the active height in bits 26:16. Address 1 holds the horizontal front porch in bits 10:0, the sync width in bits 21:11 and the back porch in bits 31:22. Each line runs active, front porch, sync, back porch. hsync is asserted only during the sync cycles.
- R3: Address 2 holds the vertical porch and sync fields in the same bit positions, counted in lines. Each frame runs active lines, front porch, sync, back porch. vsync is asserted for exactly the sync lines.
- R4: Every output is registered. The outputs one edge after the counters hold column h, row v show pix_x = h and pix_y = v. de is high only when h is below the width and v is below the height.
- R5: In pass mode, pix_out carries pix_in, sampled on the same edge, while de is high. It is zero while de is low.
- R6: In bar mode, addresses 8 to 15 hold bar colours 0 to 7, with red in bits 23:16, green in 15:8 and blue in 7:0. Column h shows bar min(h / (width/8), 7), with bar 0 at the left.
- R7: The polarity word (address 4) inverts hsync with bit 0, vsync with bit 1 and csync with bit 2. csync is active while either sync is active. While the generator is off, each output sits at its polarity bit.
- R8: Status bit 0 (address 5) is set on the edge where the counters reach column 0 of the first line after the active rows. Writing a 1 to a status bit clears it.
- R9: The mask word (address 6, 6 bits) blocks each status source whose mask bit is 1. irq is high while any unmasked status bit is set.
- R10: When the vertical-blank set and a write-one-to-clear of status bit 0 fall on the same edge, the bit ends up set.
- R11: Timing and size words written while the generator runs take effect at the next frame start. Words written while it is off apply from the first cycle of the next run.
- R12: cfg_rdata presents the addressed word, registered on the edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| pix_in | input | 24 | Incoming RGB pixel for pass mode |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| csync | output | 1 | Composite sync after polarity |
| de | output | 1 | Active-area data enable |
| pix_x | output | 11 | Current column |
| pix_y | output | 11 | Current row |
| pix_out | output | 24 | Outgoing RGB pixel |
| irq | output | 1 | Unmasked status pending |

## Verification
Two functions can land on the same edge: the counter-driven vertical-blank set of status bit 0, and a software write that clears that bit. The bench first clears the status word. It then restarts the generator, counts cycles from the enabling write, and drives a write-one-to-clear so that it is sampled on the very edge where the counters reach the first blank line. Reading status back on the next cycle must show bit 0 still set, with irq high. A separately timed clear, well away from that edge, must leave both low.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // field width fixed by the register layout
  localparam int FLD_W = 11;
  localparam int RGB_W = 24;

  // word indices
  localparam int A_MODE = 0;
  localparam int A_HTIM = 1;
  localparam int A_VTIM = 2;
  localparam int A_SIZE = 3;
  localparam int A_POL  = 4;
  localparam int A_STAT = 5;
  localparam int A_MASK = 6;

  localparam logic [2:0] MODE_OFF  = 3'd0;
  localparam logic [2:0] MODE_PASS = 3'd1;
  localparam logic [2:0] MODE_BARS = 3'd4;

  localparam int SRC_VBL = 0;

  typedef struct packed {
    logic [FLD_W-1:0] act;
    logic [FLD_W-1:0] fp;
    logic [FLD_W-1:0] pw;
    logic [FLD_W-1:0] bp;
  } axis_cfg_t;
endpackage

// File: rtl/rtc_axis_counter.sv
module rtc_axis_counter
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             step,
  input  axis_cfg_t        cfg,
  output logic [FLD_W-1:0] cnt,
  output logic             last,
  output logic             active,
  output logic             sync_on
);
  localparam int SW = FLD_W + 2;

  logic [SW-1:0] s_beg, s_end, total, cnt_x;

  assign s_beg  = SW'(cfg.act) + SW'(cfg.fp);
  assign s_end  = s_beg + SW'(cfg.pw);
  assign total  = s_end + SW'(cfg.bp);
  assign cnt_x  = SW'(cnt);
  assign last   = (cnt_x == total - 1'b1);
  assign active = (cnt < cfg.act);
  assign sync_on = (cnt_x >= s_beg) && (cnt_x < s_end);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (step)   cnt <= last ? '0 : FLD_W'(cnt + 1'b1);
  end
endmodule

// File: rtl/rtc_bar_sel.sv
module rtc_bar_sel
  import rtc_pkg::*;
#(
  parameter int NBARS = 8,
  localparam int IW = $clog2(NBARS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             line_end,
  input  logic             active,
  input  logic [FLD_W-1:0] width,
  output logic [IW-1:0]    idx
);
  logic [FLD_W-1:0] bar_w, bcnt;

  assign bar_w = width >> IW;

  always_ff @(posedge clk) begin
    if (rst || !run || line_end) begin
      bcnt <= '0;
      idx  <= '0;
    end else if (active) begin
      if (bcnt == FLD_W'(bar_w - 1'b1)) begin
        bcnt <= '0;
        if (idx != IW'(NBARS - 1)) idx <= IW'(idx + 1'b1);
      end else begin
        bcnt <= FLD_W'(bcnt + 1'b1);
      end
    end
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int AW       = 4,
  parameter int NBARS    = 8,
  parameter int BAR_BASE = 8,
  parameter int IRQW     = 6,
  localparam int BIW = $clog2(NBARS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             vbl_evt,
  output logic [2:0]       mode,
  output axis_cfg_t        h_cfg,
  output axis_cfg_t        v_cfg,
  output logic [2:0]       pol,
  input  logic [BIW-1:0]   bar_idx,
  output logic [RGB_W-1:0] bar_rgb,
  output logic [IRQW-1:0]  irq_stat,
  output logic [IRQW-1:0]  irq_mask,
  output logic             irq
);
  logic [31:0]      htim_q, vtim_q, size_q;
  logic [RGB_W-1:0] bar_mem [NBARS];
  logic [IRQW-1:0]  stat_n;
  logic [31:0]      rd_n;
  logic             in_bar;

  assign in_bar = (int'(addr) >= BAR_BASE) && (int'(addr) < BAR_BASE + NBARS);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MODE_OFF;
      htim_q   <= '0;
      vtim_q   <= '0;
      size_q   <= '0;
      pol      <= '0;
      irq_mask <= '0;
    end else if (wr) begin
      case (int'(addr))
        A_MODE: mode     <= wdata[2:0];
        A_HTIM: htim_q   <= wdata;
        A_VTIM: vtim_q   <= wdata;
        A_SIZE: size_q   <= wdata;
        A_POL:  pol      <= wdata[2:0];
        A_MASK: irq_mask <= wdata[IRQW-1:0];
        default: ;
      endcase
    end
  end

  // colour words: plain RAM, no reset
  always_ff @(posedge clk) begin
    if (wr && in_bar) bar_mem[BIW'(int'(addr) - BAR_BASE)] <= wdata[RGB_W-1:0];
  end
  assign bar_rgb = bar_mem[bar_idx];

  always_comb begin
    stat_n = irq_stat;
    if (wr && int'(addr) == A_STAT) stat_n = irq_stat & ~wdata[IRQW-1:0];
    if (vbl_evt) stat_n[SRC_VBL] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_stat <= '0;
    else     irq_stat <= stat_n;
  end

  assign irq = |(irq_stat & ~irq_mask);

  always_comb begin
    case (int'(addr))
      A_MODE:  rd_n = {29'd0, mode};
      A_HTIM:  rd_n = htim_q;
      A_VTIM:  rd_n = vtim_q;
      A_SIZE:  rd_n = size_q;
      A_POL:   rd_n = {29'd0, pol};
      A_STAT:  rd_n = {{(32-IRQW){1'b0}}, irq_stat};
      A_MASK:  rd_n = {{(32-IRQW){1'b0}}, irq_mask};
      default: rd_n = in_bar ? {{(32-RGB_W){1'b0}}, bar_mem[BIW'(int'(addr) - BAR_BASE)]} : 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_n;
  end

  assign h_cfg = '{act: size_q[10:0],  fp: htim_q[10:0], pw: htim_q[21:11], bp: {1'b0, htim_q[31:22]}};
  assign v_cfg = '{act: size_q[26:16], fp: vtim_q[10:0], pw: vtim_q[21:11], bp: {1'b0, vtim_q[31:22]}};
endmodule

// File: rtl/raster_timing_ctrl.sv
module raster_timing_ctrl
  import rtc_pkg::*;
#(
  parameter int AW       = 4,
  parameter int NBARS    = 8,
  parameter int BAR_BASE = 8,
  parameter int IRQW     = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [RGB_W-1:0] pix_in,
  output logic             hsync,
  output logic             vsync,
  output logic             csync,
  output logic             de,
  output logic [FLD_W-1:0] pix_x,
  output logic [FLD_W-1:0] pix_y,
  output logic [RGB_W-1:0] pix_out,
  output logic             irq
);
  localparam int BIW = $clog2(NBARS);

  logic [2:0]       mode, pol;
  axis_cfg_t        h_live, v_live, h_sh, v_sh;
  logic [FLD_W-1:0] hcnt, vcnt;
  logic             hlast, vlast, h_act, v_act, h_syn, v_syn;
  logic             run, frame_end, vbl_evt, de_n, hs_a, vs_a;
  logic [BIW-1:0]   bar_idx;
  logic [RGB_W-1:0] bar_rgb;
  logic [IRQW-1:0]  irq_stat, irq_mask;

  rtc_regfile #(.AW(AW), .NBARS(NBARS), .BAR_BASE(BAR_BASE), .IRQW(IRQW)) u_regs (
    .clk(clk), .rst(rst), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .vbl_evt(vbl_evt), .mode(mode), .h_cfg(h_live),
    .v_cfg(v_live), .pol(pol), .bar_idx(bar_idx), .bar_rgb(bar_rgb),
    .irq_stat(irq_stat), .irq_mask(irq_mask), .irq(irq)
  );

  assign run       = (mode == MODE_PASS) || (mode == MODE_BARS);
  assign frame_end = hlast && vlast;

  // timing shadows: follow the live words while idle, else reload per frame
  always_ff @(posedge clk) begin
    if (rst || !run || frame_end) begin
      h_sh <= h_live;
      v_sh <= v_live;
    end
  end

  rtc_axis_counter u_hcnt (
    .clk(clk), .rst(rst), .run(run), .step(1'b1), .cfg(h_sh),
    .cnt(hcnt), .last(hlast), .active(h_act), .sync_on(h_syn)
  );

  rtc_axis_counter u_vcnt (
    .clk(clk), .rst(rst), .run(run), .step(hlast), .cfg(v_sh),
    .cnt(vcnt), .last(vlast), .active(v_act), .sync_on(v_syn)
  );

  rtc_bar_sel #(.NBARS(NBARS)) u_bars (
    .clk(clk), .rst(rst), .run(run), .line_end(hlast), .active(h_act),
    .width(h_sh.act), .idx(bar_idx)
  );

  assign vbl_evt = run && (hcnt == '0) && (vcnt == v_sh.act);
  assign de_n    = run && h_act && v_act;
  assign hs_a    = run && h_syn;
  assign vs_a    = run && v_syn;

  always_ff @(posedge clk) begin
    if (rst) begin
      de      <= 1'b0;
      hsync   <= 1'b0;
      vsync   <= 1'b0;
      csync   <= 1'b0;
      pix_x   <= '0;
      pix_y   <= '0;
      pix_out <= '0;
    end else begin
      de      <= de_n;
      hsync   <= hs_a ^ pol[0];
      vsync   <= vs_a ^ pol[1];
      csync   <= (hs_a || vs_a) ^ pol[2];
      pix_x   <= run ? hcnt : '0;
      pix_y   <= run ? vcnt : '0;
      pix_out <= !de_n ? '0 : ((mode == MODE_BARS) ? bar_rgb : pix_in);
    end
  end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
  import rtc_pkg::*;
#(
  parameter int AW   = 4,
  parameter int IRQW = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             de,
  input logic [FLD_W-1:0] pix_x,
  input logic [FLD_W-1:0] pix_y,
  input logic             vbl_evt,
  input logic             stat0,
  input logic [IRQW-1:0]  irq_mask,
  input logic             irq,
  input logic             cfg_wr,
  input logic [AW-1:0]    cfg_addr,
  input logic             clr0
);
  logic clr_hit;
  assign clr_hit = cfg_wr && (cfg_addr == AW'(A_STAT)) && clr0;

  p_off_blank_r1: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!de && pix_x == '0 && pix_y == '0));

  p_x_step_r4: assert property (@(posedge clk) disable iff (rst)
    (de && $past(de) && pix_y == $past(pix_y)) |-> (pix_x == FLD_W'($past(pix_x) + 1'b1)));

  p_vbl_sets_r8: assert property (@(posedge clk) disable iff (rst)
    vbl_evt |=> stat0);

  p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && !vbl_evt) |=> !stat0);

  p_mask_all_r9: assert property (@(posedge clk) disable iff (rst)
    (&irq_mask) |-> !irq);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && vbl_evt) |=> stat0);
endmodule

bind raster_timing_ctrl rtc_checker #(.AW(AW), .IRQW(IRQW)) u_chk (
  .clk(clk), .rst(rst), .run(run), .de(de), .pix_x(pix_x), .pix_y(pix_y),
  .vbl_evt(vbl_evt), .stat0(irq_stat[0]), .irq_mask(irq_mask), .irq(irq),
  .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .clr0(cfg_wdata[0])
);

// File: tb/sim_raster_timing_ctrl.sv
module sim_raster_timing_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [23:0] pix_in = '0;
  logic        hsync, vsync, csync, de, irq;
  logic [10:0] pix_x, pix_y;
  logic [23:0] pix_out;

  int nchk = 0;
  int nfail = 0;
  int unsigned ecount = 0;
  int unsigned e0 = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) ecount <= ecount + 1;

  raster_timing_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pix_in(pix_in),
    .hsync(hsync), .vsync(vsync), .csync(csync), .de(de), .pix_x(pix_x),
    .pix_y(pix_y), .pix_out(pix_out), .irq(irq)
  );

  // probe vectors: index counted from the enabling write,
  // htotal 22 (16/2/3/1), vtotal 8 (4/1/2/1), pix_in ABCDEF, polarity 0
  typedef struct packed {
    logic [15:0] idx;
    logic        de, hs, vs;
    logic [10:0] x, y;
    logic [23:0] pix;
  } probe_t;

  localparam probe_t PROBES [12] = '{
    '{16'd0,   1'b1, 1'b0, 1'b0, 11'd0,  11'd0, 24'hABCDEF},
    '{16'd15,  1'b1, 1'b0, 1'b0, 11'd15, 11'd0, 24'hABCDEF},
    '{16'd16,  1'b0, 1'b0, 1'b0, 11'd16, 11'd0, 24'h0},
    '{16'd18,  1'b0, 1'b1, 1'b0, 11'd18, 11'd0, 24'h0},
    '{16'd20,  1'b0, 1'b1, 1'b0, 11'd20, 11'd0, 24'h0},
    '{16'd21,  1'b0, 1'b0, 1'b0, 11'd21, 11'd0, 24'h0},
    '{16'd25,  1'b1, 1'b0, 1'b0, 11'd3,  11'd1, 24'hABCDEF},
    '{16'd88,  1'b0, 1'b0, 1'b0, 11'd0,  11'd4, 24'h0},
    '{16'd110, 1'b0, 1'b0, 1'b1, 11'd0,  11'd5, 24'h0},
    '{16'd128, 1'b0, 1'b1, 1'b1, 11'd18, 11'd5, 24'h0},
    '{16'd154, 1'b0, 1'b0, 1'b0, 11'd0,  11'd7, 24'h0},
    '{16'd176, 1'b1, 1'b0, 1'b0, 11'd0,  11'd0, 24'hABCDEF}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge, returns at the following negedge
  task automatic wr(input int a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    cfg_addr = AW'(a);
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic enable(input logic [2:0] m);
    wr(0, {29'd0, m});
    e0 = ecount;
  endtask

  task automatic wait_idx(input int i);
    while (ecount < e0 + 1 + i) @(negedge clk);
  endtask

  function automatic logic [23:0] bar_col(input int b);
    return {8'(16*b + 1), 8'(32*b), 8'(255 - b)};
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state, R1
    chk("R1 reset de", de, 0);
    chk("R1 reset hsync", hsync, 0);
    chk("R1 reset pix_x", pix_x, 0);
    chk("R9 reset irq", irq, 0);
    rd(0, rv); chk("R12 mode readback", rv, 0);

    // configure, R12 readback
    wr(1, (32'd1 << 22) | (32'd3 << 11) | 32'd2);
    wr(2, (32'd1 << 22) | (32'd2 << 11) | 32'd1);
    wr(3, (32'd4 << 16) | 32'd16);
    rd(1, rv); chk("R12 htim readback", rv, (1 << 22) | (3 << 11) | 2);

    // pass mode walked through the probe table: R2 R3 R4 R5 R7
    pix_in = 24'hABCDEF;
    enable(3'd1);
    for (int k = 0; k < 12; k++) begin
      wait_idx(int'(PROBES[k].idx));
      chk("R2 de", de, PROBES[k].de);
      chk("R2 hsync", hsync, PROBES[k].hs);
      chk("R3 vsync", vsync, PROBES[k].vs);
      chk("R7 csync", csync, PROBES[k].hs | PROBES[k].vs);
      chk("R4 pix_x", pix_x, PROBES[k].x);
      chk("R3 pix_y", pix_y, PROBES[k].y);
      chk("R5 pix_out", pix_out, PROBES[k].pix);
    end

    // interrupt status and mask: R8 R9
    rd(5, rv); chk("R8 status set", rv, 1);
    chk("R9 irq pending", irq, 1);
    wr(6, 32'h1);
    chk("R9 masked irq", irq, 0);
    wr(6, 32'h0);
    chk("R9 unmasked irq", irq, 1);
    wr(5, 32'h1);
    rd(5, rv); chk("R8 w1c clears", rv, 0);
    chk("R9 irq after clear", irq, 0);

    // unsupported mode acts as off: R1
    wr(0, 32'd2);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (de || hsync || vsync || pix_x != 0 || pix_y != 0)
        chk("R1 idle in mode 2", 1, 0);
    end
    chk("R1 idle de", de, 0);

    // polarity: R7
    wr(4, 32'h7);
    @(negedge clk);
    chk("R7 off hsync level", hsync, 1);
    chk("R7 off vsync level", vsync, 1);
    chk("R7 off csync level", csync, 1);
    enable(3'd1);
    wait_idx(18);
    chk("R7 inverted hsync active", hsync, 0);
    chk("R7 inverted vsync idle", vsync, 1);
    chk("R7 inverted csync active", csync, 0);
    wr(0, 32'd0);
    wr(4, 32'h0);

    // same-edge set and clear: R10
    wr(5, 32'h3f);
    rd(5, rv); chk("R8 status cleared", rv, 0);
    enable(3'd1);
    wait_idx(87);
    wr(5, 32'h1);
    rd(5, rv); chk("R10 set wins over clear", rv, 1);
    chk("R10 irq", irq, 1);

    // stopping mid-frame: R1
    wait_idx(120);
    wr(0, 32'd0);
    @(negedge clk);
    chk("R1 stop de", de, 0);
    chk("R1 stop pix_x", pix_x, 0);
    chk("R1 stop pix_y", pix_y, 0);
    wr(5, 32'h3f);

    // colour bars: R6
    for (int b = 0; b < 8; b++) wr(8 + b, {8'd0, bar_col(b)});
    rd(13, rv); chk("R12 bar readback", rv, {8'd0, bar_col(5)});
    enable(3'd4);
    for (int b = 0; b < 8; b++) begin
      wait_idx(2 * b);
      chk("R6 bar left column", pix_out, bar_col(b));
      wait_idx(2 * b + 1);
      chk("R6 bar right column", pix_out, bar_col(b));
    end
    wait_idx(16);
    chk("R6 blank after bars", pix_out, 0);
    wait_idx(22 + 14);
    chk("R6 next line bar 7", pix_out, bar_col(7));

    // deferred timing: R11
    wr(0, 32'd0);
    enable(3'd1);
    wait_idx(25);
    wr(3, (32'd4 << 16) | 32'd8);
    wait_idx(34);
    chk("R11 old width held", de, 1);
    wait_idx(183);
    chk("R11 new frame x", pix_x, 7);
    chk("R11 new frame de in", de, 1);
    wait_idx(186);
    chk("R11 new width applied", de, 0);

    // written while off applies at once: R11
    wr(0, 32'd0);
    wr(3, (32'd4 << 16) | 32'd12);
    enable(3'd1);
    wait_idx(11);
    chk("R11 idle write last column", de, 1);
    wait_idx(12);
    chk("R11 idle write porch", de, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule